// File: doc/BRIEF.md
# Two-Level Three-Source Interrupt Controller

This block arbitrates between three interrupt sources: two external request lines and one timer overflow pulse. It presents one request at a time to the CPU, along with the index of the winning source and its service entry address. The CPU answers with an acknowledge pulse when it takes the request and with a return pulse when the service routine ends. Each source has its own enable bit and its own priority bit. A global enable gates all three sources.

Each external line is active low. Each line can be used in one of two ways. In level mode it requests while it is held low. In edge mode a falling edge sets a latch, and the acknowledge clears that latch. A timer overflow pulse is always latched, and the acknowledge clears it. The controller keeps one in-service flag per priority level. From these two flags it decides whether a new request may preempt the routine that is running. Requests at the same level are resolved by a fixed polling order: external 0 first, then the timer, then external 1.

Top module: `intc_top`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `irq` is low, both in-service flags are clear and no latched request is kept.
- R2: Source index 0 is external 0, index 1 is the timer and index 2 is external 1. The entry address is index*8+3, which gives 0x0003, 0x000B and 0x0013.
- R3: In edge mode (`ext_edge[i]`=1), a falling edge on `ext_n[i]` is latched and stays pending until that source is acknowledged. After the acknowledge, a line that is still held low raises no new request.
- R4: In level mode (`ext_edge[i]`=0), the source requests for as long as `ext_n[i]` is low, and nothing is latched. It requests again after its return if the line is still low. It stops requesting once the line goes high.
- R5: A one-cycle `tmr_ovf` pulse is latched as a timer request. The acknowledge of index 1 clears it.
- R6: A source raises `irq` only while both its `src_en` bit and `glb_en` are 1. A latched request that comes in while the source is disabled stays pending and is served once the source is enabled.
- R7: When requests of both levels are pending, a high-level request (`src_hi[i]`=1) is presented first.
- R8: Among pending requests of the same level, the lowest index wins: 0, then 1, then 2.
- R9: While a low-level routine is in service, only a high-level request can raise `irq`.
- R10: While a high-level routine is in service, no request raises `irq`.
- R11: `reti` clears the high in-service flag if it is set, and otherwise clears the low one. After a nested return, the outer low-level routine still blocks low requests.
- R12: `irq` is registered. It rises two clock edges after a level-mode line falls or a timer pulse is sampled. It rises three edges after an edge-mode line falls. It falls at the edge that samples `ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_n | input | 2 | External request lines, active low (bit 0 is external 0) |
| ext_edge | input | 2 | Per line: 1 selects falling-edge mode, 0 selects level mode |
| tmr_ovf | input | 1 | Timer overflow pulse |
| glb_en | input | 1 | Global enable |
| src_en | input | 3 | Per-source enable, indexed by source index |
| src_hi | input | 3 | Per-source priority, 1 selects the high level |
| ack | input | 1 | CPU accepts the presented request |
| reti | input | 1 | CPU returns from a service routine |
| irq | output | 1 | Request to the CPU |
| irq_idx | output | 2 | Index of the presented source |
| irq_hi | output | 1 | Level of the presented source |
| irq_addr | output | 16 | Entry address of the presented source |

## Verification
Two register stages lie between a level-mode line or a timer pulse and `irq`, and three lie between an edge-mode line and `irq`. The bench checks the level-mode latency at exactly those negative edges: low after one edge and high after two. It also checks that `irq` is low one edge after the acknowledge. Where the order of service matters more than the exact cycle, the driver queues the expected source indices. The monitor then waits a bounded number of cycles for each request, compares it, acknowledges it and returns from it. Checks that nothing is raised are made several cycles after the stimulus, so that every possible pipeline delay has passed.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC  = 3;
  localparam int NEXT  = 2;
  localparam int IDX_W = 2;
  localparam int NLVL  = 2;

  // slot numbers double as polling rank (lower wins)
  typedef enum logic [IDX_W-1:0] {
    SLOT_X0  = 2'd0,
    SLOT_TMR = 2'd1,
    SLOT_X1  = 2'd2
  } slot_e;

  function automatic logic [15:0] entry_of(input logic [IDX_W-1:0] idx,
                                           input int base, input int stride);
    entry_of = 16'(base + stride * int'(idx));
  endfunction
endpackage

// File: rtl/intc_flag.sv
module intc_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= (q & ~clr) | set;
  end
endmodule

// File: rtl/intc_ext_req.sv
module intc_ext_req (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic smp_q, prv_q, lat_q;
  logic fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q <= 1'b1;
      prv_q <= 1'b1;
    end else begin
      smp_q <= pin_n;
      prv_q <= smp_q;
    end
  end

  assign fall = edge_mode & prv_q & ~smp_q;

  intc_flag u_lat (
    .clk (clk),
    .rst (rst),
    .set (fall),
    .clr (clr | ~edge_mode),
    .q   (lat_q)
  );

  assign req = edge_mode ? lat_q : ~smp_q;
endmodule

// File: rtl/intc_arb.sv
module intc_arb
  import intc_pkg::*;
(
  input  logic [NSRC-1:0]  req,
  input  logic [NSRC-1:0]  en,
  input  logic [NSRC-1:0]  hi,
  input  logic             glb,
  input  logic [NLVL-1:0]  in_svc,
  output logic             grant,
  output logic [IDX_W-1:0] gidx,
  output logic             glvl
);
  logic [NSRC-1:0] elig, hreq, lreq, pick;

  assign elig = req & en & {NSRC{glb}};
  assign hreq = elig & hi;
  assign lreq = elig & ~hi;

  always_comb begin
    glvl = 1'b0;
    pick = '0;
    if (!in_svc[1]) begin
      if (|hreq) begin
        pick = hreq;
        glvl = 1'b1;
      end else if (!in_svc[0]) begin
        pick = lreq;
      end
    end
  end

  always_comb begin
    grant = |pick;
    gidx  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pick[i]) gidx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/intc_nest.sv
module intc_nest
  import intc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            take_lvl,
  input  logic            reti,
  output logic [NLVL-1:0] in_svc
);
  logic [NLVL-1:0] clr_v, set_v;

  always_comb begin
    clr_v = '0;
    if (reti) clr_v = in_svc[1] ? 2'b10 : 2'b01;
    set_v = '0;
    if (take) set_v[take_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) in_svc <= '0;
    else     in_svc <= (in_svc & ~clr_v) | set_v;
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NEXT-1:0]  ext_n,
  input  logic [NEXT-1:0]  ext_edge,
  input  logic             tmr_ovf,
  input  logic             glb_en,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  src_hi,
  input  logic             ack,
  input  logic             reti,
  output logic             irq,
  output logic [IDX_W-1:0] irq_idx,
  output logic             irq_hi,
  output logic [15:0]      irq_addr
);
  logic [NSRC-1:0]  req, clr;
  logic [NLVL-1:0]  in_svc;
  logic             take, grant, glvl;
  logic [IDX_W-1:0] gidx;

  assign take = ack & irq;

  always_comb begin
    clr = '0;
    if (take) clr[irq_idx] = 1'b1;
  end

  // external lines land on even slots: 0 and 2
  for (genvar e = 0; e < NEXT; e++) begin : g_ext
    intc_ext_req u_req (
      .clk       (clk),
      .rst       (rst),
      .pin_n     (ext_n[e]),
      .edge_mode (ext_edge[e]),
      .clr       (clr[2*e]),
      .req       (req[2*e])
    );
  end

  intc_flag u_tmr (
    .clk (clk),
    .rst (rst),
    .set (tmr_ovf),
    .clr (clr[SLOT_TMR]),
    .q   (req[SLOT_TMR])
  );

  intc_arb u_arb (
    .req    (req),
    .en     (src_en),
    .hi     (src_hi),
    .glb    (glb_en),
    .in_svc (in_svc),
    .grant  (grant),
    .gidx   (gidx),
    .glvl   (glvl)
  );

  intc_nest u_nest (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .take_lvl (irq_hi),
    .reti     (reti),
    .in_svc   (in_svc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      irq_idx  <= '0;
      irq_hi   <= 1'b0;
      irq_addr <= entry_of('0, VEC_BASE, VEC_STRIDE);
    end else if (take) begin
      irq <= 1'b0;
    end else begin
      irq      <= grant;
      irq_idx  <= gidx;
      irq_hi   <= glvl;
      irq_addr <= entry_of(gidx, VEC_BASE, VEC_STRIDE);
    end
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq,
  input logic       irq_hi,
  input logic       ack,
  input logic       reti,
  input logic       glb_en,
  input logic [1:0] in_svc
);
  // R1
  rst_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !irq);
  // R10
  hi_block_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> !in_svc[1]);
  // R9
  lo_nest_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && in_svc[0]) |-> irq_hi);
  // R12
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && irq) |=> !irq);
  // R11
  reti_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (reti && !ack && in_svc == 2'b11) |=> (in_svc == 2'b01));
  // R6
  glb_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(glb_en));
endmodule

bind intc_top intc_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .irq    (irq),
  .irq_hi (irq_hi),
  .ack    (ack),
  .reti   (reti),
  .glb_en (glb_en),
  .in_svc (in_svc)
);

// File: tb/tb_intc_top.sv
module tb_intc_top;
  localparam int CLK_P = 10;
  localparam int WDOG  = 20000;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] ext_n, ext_edge;
  logic       tmr_ovf, glb_en, ack, reti;
  logic [2:0] src_en, src_hi;
  logic       irq, irq_hi;
  logic [1:0] irq_idx;
  logic [15:0] irq_addr;

  int n_chk = 0;
  int n_fail = 0;
  int cyc_cnt = 0;
  int exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  intc_top dut (
    .clk(clk), .rst(rst), .ext_n(ext_n), .ext_edge(ext_edge),
    .tmr_ovf(tmr_ovf), .glb_en(glb_en), .src_en(src_en), .src_hi(src_hi),
    .ack(ack), .reti(reti), .irq(irq), .irq_idx(irq_idx),
    .irq_hi(irq_hi), .irq_addr(irq_addr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_exp(input int idx);
    exp_q.push_back(idx);
  endtask

  // monitor: wait for a request, pop expected, compare, acknowledge
  task automatic service(input string tag);
    int exp_idx;
    int w;
    w = 0;
    while (!irq && w < 20) begin
      cyc(1);
      w++;
    end
    exp_idx = exp_q.pop_front();
    check(irq == 1'b1, {tag, " irq"}, int'(irq), 1);
    check(int'(irq_idx) == exp_idx, {tag, " idx"}, int'(irq_idx), exp_idx);
    check(int'(irq_addr) == exp_idx * 8 + 3, {tag, " R2 addr"},
          int'(irq_addr), exp_idx * 8 + 3);
    ack = 1'b1;
    cyc(1);
    ack = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1;
    cyc(1);
    reti = 1'b0;
  endtask

  task automatic quiet(input int n, input string tag);
    cyc(n);
    check(irq == 1'b0, tag, int'(irq), 0);
  endtask

  initial begin
    while (1) begin
      @(negedge clk);
      cyc_cnt++;
      if (cyc_cnt > WDOG) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc_cnt, WDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; ext_n = 2'b11; ext_edge = 2'b11; tmr_ovf = 1'b0;
    glb_en = 1'b1; src_en = 3'b111; src_hi = 3'b000; ack = 1'b0; reti = 1'b0;
    cyc(4);
    rst = 1'b0;
    cyc(1);
    check(irq == 1'b0, "R1 reset idle", int'(irq), 0);

    // R12 / R4: level-mode latency on external 1
    ext_edge = 2'b01;
    cyc(2);
    ext_n[1] = 1'b0;
    cyc(1);
    check(irq == 1'b0, "R12 one edge", int'(irq), 0);
    cyc(1);
    check(irq == 1'b1, "R12 two edges", int'(irq), 1);
    push_exp(2);
    service("R4 level");
    check(irq == 1'b0, "R12 ack drop", int'(irq), 0);
    do_reti();
    push_exp(2);
    service("R4 rerequest");
    ext_n[1] = 1'b1;
    cyc(2);
    do_reti();
    quiet(5, "R4 released");

    // R3: edge mode, held low
    ext_edge = 2'b11;
    cyc(2);
    ext_n[0] = 1'b0;
    push_exp(0);
    service("R3 edge");
    do_reti();
    quiet(6, "R3 held low no repeat");
    ext_n[0] = 1'b1;
    cyc(2);

    // R5: timer pulse
    tmr_ovf = 1'b1;
    cyc(1);
    tmr_ovf = 1'b0;
    push_exp(1);
    service("R5 timer");
    do_reti();
    quiet(5, "R5 cleared");

    // R6 global gate, then R8 polling order
    glb_en = 1'b0;
    ext_n = 2'b00;
    tmr_ovf = 1'b1;
    cyc(1);
    tmr_ovf = 1'b0;
    quiet(6, "R6 global off");
    glb_en = 1'b1;
    push_exp(0); push_exp(1); push_exp(2);
    service("R8 first");
    do_reti();
    service("R8 second");
    do_reti();
    service("R8 third");
    do_reti();
    ext_n = 2'b11;
    quiet(5, "R8 drained");

    // R7, R10, R9, R11
    src_hi = 3'b100;
    glb_en = 1'b0;
    ext_n = 2'b00;
    cyc(4);
    glb_en = 1'b1;
    push_exp(2);
    service("R7 high first");
    check(irq_hi == 1'b1 || irq == 1'b0, "R7 level", int'(irq_hi), 1);
    tmr_ovf = 1'b1;
    cyc(1);
    tmr_ovf = 1'b0;
    quiet(6, "R10 high in service");
    do_reti();
    push_exp(0);
    service("R10 then low");
    quiet(6, "R9 low blocks low");
    ext_n[1] = 1'b1;
    cyc(2);
    ext_n[1] = 1'b0;
    push_exp(2);
    service("R9 high nests");
    do_reti();
    quiet(6, "R11 outer low still blocks");
    do_reti();
    push_exp(1);
    service("R11 timer after both returns");
    do_reti();
    ext_n = 2'b11;
    src_hi = 3'b000;
    quiet(5, "R11 idle");

    // R6 source enable keeps latched request
    src_en = 3'b110;
    ext_n[0] = 1'b0;
    quiet(6, "R6 source off");
    src_en = 3'b111;
    push_exp(0);
    service("R6 served when enabled");
    do_reti();
    ext_n[0] = 1'b1;
    quiet(5, "R6 idle");
    check(exp_q.size() == 0, "scoreboard empty", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule